// File: doc/BRIEF.md
# Illegal Instruction Classifier

This block screens every decoded 16-bit instruction word and decides whether it must be refused. It raises one of two exception requests. A general illegal instruction request covers an undefined opcode or a privileged instruction issued in user mode. An illegal slot instruction request covers a forbidden instruction placed in the delay slot of a delayed branch. The predecoder supplies class flags beside the opcode: delayed branch, PC write, privileged, and GBR access. The block uses these flags, not a full opcode table.

The block keeps one bit of state, which records whether the next valid instruction sits in a delay slot. Both requests are combinational and are qualified by the valid strobe in the same cycle. An event code output carries the code that matches whichever request is active. The exception entry logic downstream samples the requests and the event code. The pipeline raises a flush input when it discards the instruction stream, and the flush drops any pending slot.

Top module: `illegal_insn_screen`

## Requirements
- R1: With no slot pending, a valid undefined opcode raises `gen_illegal_req` in the same cycle, and `evt_code` reads H'180. While no request is active, `evt_code` reads 0.
- R2: The undefined space depends on `sr_cl`. When `sr_cl`=0, a word is undefined if bits [15:12] are all ones. When `sr_cl`=1, a word is undefined only if bits [15:10] are all ones.
- R3: With no slot pending, a valid instruction with `is_priv`=1 and `sr_md`=0 (user mode) raises `gen_illegal_req`. The request is not raised if `is_gbr_access`=1 or `sr_md`=1.
- R4: With a slot pending, a valid instruction that is undefined, or that has `is_pc_write` or `is_dly_branch` set, raises `slot_illegal_req`, and `evt_code` reads H'1A0.
- R5: With a slot pending, a privileged instruction in user mode raises `slot_illegal_req` and never `gen_illegal_req`.
- R6: At most one request is active in a cycle. When both conditions hold, the slot request wins.
- R7: A valid delayed branch that raises no request opens a slot for exactly the next valid instruction. Cycles with `ins_valid`=0 do not consume the slot. A delayed branch that is itself refused opens no slot.
- R8: Reset clears the pending slot. So does `flush`, which also overrides a delayed branch presented in the same cycle.
- R9: No request is raised while `ins_valid` is low, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Discard a pending delay slot |
| ins_valid | input | 1 | Instruction word valid this cycle |
| ins_word | input | 16 | Decoded instruction opcode |
| is_dly_branch | input | 1 | Instruction is a delayed branch |
| is_pc_write | input | 1 | Instruction rewrites the PC |
| is_priv | input | 1 | Instruction is in the privileged class |
| is_gbr_access | input | 1 | Control-register form that targets GBR |
| sr_md | input | 1 | Status mode bit, 1 = privileged |
| sr_cl | input | 1 | Status bit narrowing the undefined space |
| gen_illegal_req | output | 1 | General illegal instruction request |
| slot_illegal_req | output | 1 | Illegal slot instruction request |
| evt_code | output | 12 | Event code of the active request, 0 if none |

## Verification
The bench sweeps every combination of pending slot, CL, mode bit, the four class flags, and opcodes on and around both edges of the undefined space. The word H'F000 is undefined only when CL is clear. A design that ignored CL would refuse it in both modes, or would accept H'FC00 in one of them. After each swept instruction, an undefined probe shows whether a slot was left open. A design that let a refused branch open a slot, or that kept the slot past one instruction, would turn the probe's general request into a slot request. Further cases cover flush against a delayed branch in the same cycle, and idle cycles inside a slot. A design that spent the slot on an idle cycle would report the wrong request class.

// File: rtl/illegal_insn_screen.sv
module illegal_insn_screen #(
  parameter int EVT_W = 12,
  parameter logic [EVT_W-1:0] EVT_GENERAL = 'h180,
  parameter logic [EVT_W-1:0] EVT_SLOT = 'h1A0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             ins_valid,
  input  logic [15:0]      ins_word,
  input  logic             is_dly_branch,
  input  logic             is_pc_write,
  input  logic             is_priv,
  input  logic             is_gbr_access,
  input  logic             sr_md,
  input  logic             sr_cl,
  output logic             gen_illegal_req,
  output logic             slot_illegal_req,
  output logic [EVT_W-1:0] evt_code
);

  logic slot_q;
  logic undef_op;
  logic priv_user;

  assign undef_op  = sr_cl ? (&ins_word[15:10]) : (&ins_word[15:12]);
  assign priv_user = is_priv & ~is_gbr_access & ~sr_md;

  assign slot_illegal_req = ins_valid & slot_q &
                            (undef_op | is_pc_write | is_dly_branch | priv_user);
  assign gen_illegal_req  = ins_valid & ~slot_q & (undef_op | priv_user);

  assign evt_code = slot_illegal_req ? EVT_SLOT :
                    gen_illegal_req  ? EVT_GENERAL : '0;

  always_ff @(posedge clk) begin
    if (!rst_n || flush)
      slot_q <= 1'b0;
    else if (ins_valid)
      slot_q <= is_dly_branch & ~gen_illegal_req & ~slot_illegal_req;
  end

  a_r6_one_request: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({gen_illegal_req, slot_illegal_req}));

  a_r1_general_code: assert property (@(posedge clk) disable iff (!rst_n)
    gen_illegal_req |-> evt_code == EVT_GENERAL);

  a_r4_slot_code: assert property (@(posedge clk) disable iff (!rst_n)
    slot_illegal_req |-> evt_code == EVT_SLOT);

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !ins_valid |-> !gen_illegal_req && !slot_illegal_req);

  a_r8_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !slot_illegal_req);

  a_r7_slot_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && !is_dly_branch && !flush) |=> !slot_illegal_req);

  a_r7_slot_opens: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && is_dly_branch && !flush && !gen_illegal_req && !slot_illegal_req)
    |=> (!(ins_valid && (&ins_word[15:10])) || slot_illegal_req));

endmodule

// File: tb/illegal_insn_screen_tb.sv
module illegal_insn_screen_tb;
  localparam time PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flush = 1'b0;
  logic ins_valid = 1'b0;
  logic [15:0] ins_word = '0;
  logic is_dly_branch = 1'b0, is_pc_write = 1'b0, is_priv = 1'b0, is_gbr_access = 1'b0;
  logic sr_md = 1'b1, sr_cl = 1'b0;
  logic gen_illegal_req, slot_illegal_req;
  logic [11:0] evt_code;

  int checks = 0;
  int fails = 0;

  always #(PERIOD/2) clk = ~clk;

  illegal_insn_screen u_dut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .ins_valid(ins_valid),
    .ins_word(ins_word), .is_dly_branch(is_dly_branch), .is_pc_write(is_pc_write),
    .is_priv(is_priv), .is_gbr_access(is_gbr_access), .sr_md(sr_md), .sr_cl(sr_cl),
    .gen_illegal_req(gen_illegal_req), .slot_illegal_req(slot_illegal_req),
    .evt_code(evt_code)
  );

  task automatic drive(input logic v, input logic [15:0] w, input logic [3:0] fl,
                       input logic md, input logic cl, input logic fls);
    @(negedge clk);
    ins_valid = v; ins_word = w;
    {is_dly_branch, is_pc_write, is_priv, is_gbr_access} = fl;
    sr_md = md; sr_cl = cl; flush = fls;
    #1;
  endtask

  task automatic check(input string tag, input logic eg, input logic es);
    logic [11:0] ee;
    ee = es ? 12'h1A0 : (eg ? 12'h180 : 12'h000);
    checks++;
    if (gen_illegal_req !== eg || slot_illegal_req !== es || evt_code !== ee) begin
      fails++;
      $display("FAIL %s: gen/slot/code = %b/%b/%h, expected %b/%b/%h",
               tag, gen_illegal_req, slot_illegal_req, evt_code, eg, es, ee);
    end
  endtask

  initial begin
    #(PERIOD * 100000);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [15:0] ops [4];
    ops[0] = 16'h0000; ops[1] = 16'hF000; ops[2] = 16'hFC00; ops[3] = 16'hFBFF;
    repeat (3) @(negedge clk);
    #1;
    check("R8 reset idle", 1'b0, 1'b0);
    @(negedge clk); rst_n = 1'b1;

    drive(1'b1, 16'hFC00, 4'b0000, 1'b1, 1'b0, 1'b0);
    check("R8 no slot after reset", 1'b1, 1'b0);
    drive(1'b0, 16'hFC00, 4'b1111, 1'b0, 1'b1, 1'b0);
    check("R9 idle undefined", 1'b0, 1'b0);

    // slot survives idle cycles (R7)
    drive(1'b1, 16'h0000, 4'b1100, 1'b1, 1'b0, 1'b0);
    check("R7 branch accepted", 1'b0, 1'b0);
    drive(1'b0, 16'hFC00, 4'b0000, 1'b1, 1'b0, 1'b0);
    check("R9 idle in slot", 1'b0, 1'b0);
    drive(1'b0, 16'h0000, 4'b0000, 1'b1, 1'b0, 1'b0);
    drive(1'b1, 16'h0000, 4'b0100, 1'b1, 1'b0, 1'b0);
    check("R7 slot kept over idle", 1'b0, 1'b1);
    drive(1'b1, 16'h0000, 4'b0100, 1'b1, 1'b0, 1'b0);
    check("R7 slot lasts one instruction", 1'b0, 1'b0);

    // flush overrides a branch in the same cycle (R8)
    drive(1'b1, 16'h0000, 4'b1100, 1'b1, 1'b0, 1'b1);
    check("R8 branch with flush", 1'b0, 1'b0);
    drive(1'b1, 16'hFC00, 4'b0000, 1'b1, 1'b0, 1'b0);
    check("R8 flush beat branch", 1'b1, 1'b0);

    // refused branch opens no slot (R7)
    drive(1'b1, 16'hF000, 4'b1100, 1'b1, 1'b0, 1'b0);
    check("R7 undefined branch refused", 1'b1, 1'b0);
    drive(1'b1, 16'hFC00, 4'b0000, 1'b1, 1'b0, 1'b0);
    check("R7 no slot after refused branch", 1'b1, 1'b0);

    for (int s = 0; s < 2; s++)
      for (int cl = 0; cl < 2; cl++)
        for (int md = 0; md < 2; md++)
          for (int f = 0; f < 16; f++)
            for (int o = 0; o < 4; o++) begin
              logic [3:0] fl;
              logic und, pu, eg, es, opens;
              string tag;
              fl = f[3:0];
              drive(1'b0, 16'h0000, 4'b0000, 1'b1, 1'b0, 1'b1);
              if (s == 1) drive(1'b1, 16'h0000, 4'b1100, 1'b1, 1'b0, 1'b0);
              drive(1'b1, ops[o], fl, md[0], cl[0], 1'b0);
              und = (cl == 1) ? (ops[o][15:10] == 6'h3F) : (ops[o][15:12] == 4'hF);
              pu = fl[1] & ~fl[0] & ~md[0];
              es = (s == 1) & (und | fl[2] | fl[3] | pu);
              eg = (s == 0) & (und | pu);
              if (s == 1) tag = pu ? "R5 privileged in slot" : "R4 slot sweep";
              else if (und) tag = "R1/R2 undefined sweep";
              else tag = "R3 privilege sweep";
              check(tag, eg, es);
              opens = fl[3] & ~eg & ~es;
              drive(1'b1, 16'hFC00, 4'b0000, 1'b1, 1'b0, 1'b0);
              check("R6/R7 follow-up probe", ~opens, opens);
            end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule